// File: doc/BRIEF.md
# NAND Flash Host Port with Running ECC

This block sits between a simple processor register bus and a raw 8-bit NAND flash device. Software drives the command-latch, address-latch, chip-enable and write-protect pins through a control register. It moves data one byte at a time through an I/O register. Each access to the I/O register becomes a timed write or read strobe on the NAND pins. The block does no page-level sequencing of its own; software issues commands, addresses and data in the right order.

Every byte that passes through the I/O register, in either direction, is also fed into an ECC accumulator. The accumulator builds a Hamming-style code over blocks of up to 256 bytes. Software can read back its line parity, column parity and byte count, and can clear it with a single register write. A 32-bit read of the I/O register performs two NAND byte reads back to back, so software can fetch two bytes with one bus access.

Top module: `nfc_host_top`

## Requirements
- R1: After reset the control register reads 0x00 (with the ready input low), `nand_cle_o`=0, `nand_ale_o`=0, `nand_nce_o`=1, `nand_nwp_o`=1, and the line-parity, column-parity and count registers read 0.
- R2: A write to the control register at offset 0x18 drives the pins as follows: bit 1 drives `nand_cle_o`, bit 2 drives `nand_ale_o`, and bit 3 set drives `nand_nwp_o` low. `nand_nce_o` goes low when bit 0 or bit 4 is set.
- R3: Bit 5 of the control register is read-only. A read returns the stored value with bit 5 equal to `nand_rb_i`. A write stores every bit except bit 5, which it discards.
- R4: A write to the I/O register at offset 0x14 puts the low data byte on `nand_dq_o`, with `nand_dq_oe_o` high, and pulses `nand_nwe_o` low for PULSE_CYC cycles.
- R5: A byte read of the I/O register pulses `nand_nre_o` low for PULSE_CYC cycles. The byte sampled from `nand_dq_i` is returned in `rdata_o[7:0]`, with all other bits 0.
- R6: A word read of the I/O register (`word_i`=1) performs two read strobes. The first byte is returned in `rdata_o[7:0]` and the second in `rdata_o[23:16]`; all other bits are 0.
- R7: Offset 0x0C returns the low 8 bits of the number of bytes fed into the ECC since the last clear or reset. Both written and read I/O bytes count, including both bytes of a word read.
- R8: Offset 0x08 bits 5:0 return the column parities, each accumulated as an XOR over all bytes. For j = 0, 1, 2, bit 2j is the parity of the data bits whose bit index has bit j equal to 0, and bit 2j+1 is the parity of the data bits whose index has bit j equal to 1.
- R9: For each byte at position n (the count before that byte), with overall parity p, and for each k from 0 to 7: p is XORed into E[k] when bit k of n is 0, and into O[k] when it is 1. Offset 0x00 returns E[4+j] in bit 2j and O[4+j] in bit 2j+1. Offset 0x04 returns E[j] in bit 2j and O[j] in bit 2j+1, for j = 0 to 3.
- R10: A write of any value to offset 0x10 clears the line parity, column parity and count, and leaves the control register unchanged.
- R11: A read of any offset not listed above returns 0. A write to such an offset changes neither the pins nor any register.
- R12: `ack_o` pulses once per request. It comes 1 clock after the request for register accesses, PULSE_CYC+2 clocks after for an I/O byte, and 2·PULSE_CYC+3 clocks after for an I/O word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one-cycle pulse, only while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 32-bit access (two bytes on an I/O read) |
| addr_i | input | 6 | Byte offset in the 0x40 window |
| wdata_i | input | 8 | Write data |
| ack_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read data, valid with ack_o |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_nce_o | output | 1 | Chip enable, active low |
| nand_nwp_o | output | 1 | Write protect, active low |
| nand_nwe_o | output | 1 | Write strobe, active low |
| nand_nre_o | output | 1 | Read strobe, active low |
| nand_rb_i | input | 1 | Ready (1) / busy (0) from the device |
| nand_dq_i | input | 8 | Data from the device |
| nand_dq_o | output | 8 | Data to the device |
| nand_dq_oe_o | output | 1 | Data output enable |

## Verification
The request is registered at the edge that follows it. A register result is therefore due one edge later, an I/O byte PULSE_CYC+2 edges later, and a word read 2·PULSE_CYC+3 edges later. The bench counts rising edges from the request until it sees `ack_o` at a falling edge, compares that count with the expected latency, and only then takes `rdata_o`. Pin levels are sampled at the falling edge after the edge that updates them. Written bytes are captured at the rising edge of the write strobe. ECC registers are compared with a reference model that is updated for every byte transferred.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_LP_LO = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_LP_HI = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CP    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_IO    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_CTL   = 6'h18;

  localparam int CB_CE0 = 0;
  localparam int CB_CLE = 1;
  localparam int CB_ALE = 2;
  localparam int CB_WP  = 3;
  localparam int CB_CE1 = 4;
  localparam int CB_RDY = 5;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_STROBE,
    XS_HOLD
  } xfer_state_e;

  // data bits whose bit index has bit j equal to sel
  function automatic logic [7:0] col_mask(input int j, input logic sel);
    logic [7:0] m;
    for (int n = 0; n < 8; n++) m[n] = (((n >> j) & 1) == int'(sel));
    return m;
  endfunction
endpackage

// File: rtl/nfc_ecc_acc.sv
module nfc_ecc_acc
  import nfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             dig_i,
  input  logic [7:0]       byte_i,
  output logic [7:0]       lp_even_o,
  output logic [7:0]       lp_odd_o,
  output logic [5:0]       cp_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int LP_N = 8;

  logic [LP_N-1:0]  lpe_q, lpo_q, lpe_d, lpo_d;
  logic [5:0]       cp_q, cp_d;
  logic [CNT_W-1:0] cnt_q;
  logic [LP_N-1:0]  idx;
  logic             par;

  assign idx = cnt_q[LP_N-1:0];
  assign par = ^byte_i;

  always_comb begin
    for (int k = 0; k < LP_N; k++) begin
      lpe_d[k] = lpe_q[k] ^ (par & ~idx[k]);
      lpo_d[k] = lpo_q[k] ^ (par &  idx[k]);
    end
  end

  for (genvar j = 0; j < 3; j++) begin : g_col
    assign cp_d[2*j]   = cp_q[2*j]   ^ (^(byte_i & col_mask(j, 1'b0)));
    assign cp_d[2*j+1] = cp_q[2*j+1] ^ (^(byte_i & col_mask(j, 1'b1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpe_q <= '0;
      lpo_q <= '0;
      cp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      lpe_q <= '0;
      lpo_q <= '0;
      cp_q  <= '0;
      cnt_q <= '0;
    end else if (dig_i) begin
      lpe_q <= lpe_d;
      lpo_q <= lpo_d;
      cp_q  <= cp_d;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lp_even_o = lpe_q;
  assign lp_odd_o  = lpo_q;
  assign cp_o      = cp_q;
  assign cnt_o     = cnt_q;

  // R10
  clr_wipes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && cp_q == '0 && lpe_q == '0 && lpo_q == '0));
  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_i && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/nfc_xfer.sv
module nfc_xfer
  import nfc_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic        dbl_i,
  input  logic [7:0]  wbyte_i,
  input  logic [7:0]  dq_i,
  output logic        nwe_o,
  output logic        nre_o,
  output logic [7:0]  dq_o,
  output logic        dq_oe_o,
  output logic        dig_o,
  output logic [7:0]  dig_byte_o,
  output logic [15:0] rd_word_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

  xfer_state_e state_q;
  logic [PW-1:0] cnt_q;
  logic          wr_q, dbl_q, second_q, done_q;
  logic [7:0]    wbyte_q, rd_lo_q, rd_hi_q;
  logic          strobe, last;

  assign strobe = (state_q == XS_STROBE);
  assign last   = strobe && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= XS_IDLE;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      dbl_q    <= 1'b0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      wbyte_q  <= '0;
      rd_lo_q  <= '0;
      rd_hi_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        XS_IDLE: if (start_i) begin
          state_q  <= XS_STROBE;
          cnt_q    <= '0;
          wr_q     <= wr_i;
          dbl_q    <= dbl_i & ~wr_i;
          second_q <= 1'b0;
          wbyte_q  <= wbyte_i;
          rd_lo_q  <= '0;
          rd_hi_q  <= '0;
        end
        XS_STROBE: begin
          if (last) begin
            state_q <= XS_HOLD;
            if (!wr_q) begin
              if (second_q) rd_hi_q <= dq_i;
              else          rd_lo_q <= dq_i;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        XS_HOLD: begin
          if (dbl_q && !second_q) begin
            second_q <= 1'b1;
            cnt_q    <= '0;
            state_q  <= XS_STROBE;
          end else begin
            state_q <= XS_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign nwe_o      = ~(strobe & wr_q);
  assign nre_o      = ~(strobe & ~wr_q);
  assign dq_o       = wbyte_q;
  assign dq_oe_o    = wr_q & (state_q != XS_IDLE);
  assign dig_o      = last;
  assign dig_byte_o = wr_q ? wbyte_q : dq_i;
  assign rd_word_o  = {rd_hi_q, rd_lo_q};
  assign busy_o     = (state_q != XS_IDLE);
  assign done_o     = done_q;

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nwe_o && !nre_o));
  // R5
  no_drive_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> nre_o);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/nfc_host_top.sv
module nfc_host_top
  import nfc_pkg::*;
#(
  parameter int PULSE_CYC = 2,
  parameter int CNT_W     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        word_i,
  input  logic [5:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic        ack_o,
  output logic [31:0] rdata_o,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_nce_o,
  output logic        nand_nwp_o,
  output logic        nand_nwe_o,
  output logic        nand_nre_o,
  input  logic        nand_rb_i,
  input  logic [7:0]  nand_dq_i,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe_o
);
  localparam logic [7:0] CTL_WMASK = ~(8'(1) << CB_RDY);

  logic [7:0]       ctl_q;
  logic [31:0]      rdata_q;
  logic             reg_ack_q, io_sel_q;
  logic             busy, accept, is_io, is_ctl, is_clr, ecc_clr;
  logic             dig, xfer_done;
  logic [7:0]       dig_byte, reg_rd;
  logic [15:0]      rd_word;
  logic [7:0]       lp_e, lp_o, lp_lo, lp_hi;
  logic [5:0]       cp;
  logic [CNT_W-1:0] cnt;

  assign accept  = req_i & ~busy;
  assign is_io   = (addr_i == OFF_IO);
  assign is_ctl  = (addr_i == OFF_CTL);
  assign is_clr  = (addr_i == OFF_CLR);
  assign ecc_clr = accept & we_i & is_clr;

  nfc_xfer #(.PULSE_CYC(PULSE_CYC)) i_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept & is_io),
    .wr_i       (we_i),
    .dbl_i      (word_i),
    .wbyte_i    (wdata_i),
    .dq_i       (nand_dq_i),
    .nwe_o      (nand_nwe_o),
    .nre_o      (nand_nre_o),
    .dq_o       (nand_dq_o),
    .dq_oe_o    (nand_dq_oe_o),
    .dig_o      (dig),
    .dig_byte_o (dig_byte),
    .rd_word_o  (rd_word),
    .busy_o     (busy),
    .done_o     (xfer_done)
  );

  nfc_ecc_acc #(.CNT_W(CNT_W)) i_ecc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ecc_clr),
    .dig_i     (dig),
    .byte_i    (dig_byte),
    .lp_even_o (lp_e),
    .lp_odd_o  (lp_o),
    .cp_o      (cp),
    .cnt_o     (cnt)
  );

  // interleave even/odd line parities; low reg takes upper nibbles
  for (genvar j = 0; j < 4; j++) begin : g_lp
    assign lp_lo[2*j]   = lp_e[4+j];
    assign lp_lo[2*j+1] = lp_o[4+j];
    assign lp_hi[2*j]   = lp_e[j];
    assign lp_hi[2*j+1] = lp_o[j];
  end

  always_comb begin
    unique case (addr_i)
      OFF_LP_LO: reg_rd = lp_lo;
      OFF_LP_HI: reg_rd = lp_hi;
      OFF_CP:    reg_rd = {2'b00, cp};
      OFF_CNT:   reg_rd = cnt[7:0];
      OFF_CTL:   reg_rd = ctl_q | (8'(nand_rb_i) << CB_RDY);
      default:   reg_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      rdata_q   <= '0;
      reg_ack_q <= 1'b0;
      io_sel_q  <= 1'b0;
    end else begin
      reg_ack_q <= accept & ~is_io;
      if (accept) begin
        io_sel_q <= is_io;
        rdata_q  <= we_i ? 32'h0 : {24'h0, reg_rd};
        if (we_i && is_ctl) ctl_q <= wdata_i & CTL_WMASK;
      end
    end
  end

  assign ack_o   = reg_ack_q | xfer_done;
  assign rdata_o = io_sel_q ? {8'h00, rd_word[15:8], 8'h00, rd_word[7:0]} : rdata_q;

  assign nand_cle_o = ctl_q[CB_CLE];
  assign nand_ale_o = ctl_q[CB_ALE];
  assign nand_nce_o = ~(ctl_q[CB_CE0] | ctl_q[CB_CE1]);
  assign nand_nwp_o = ~ctl_q[CB_WP];

  // R2
  ctl_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && we_i && is_ctl) |=> (nand_cle_o == $past(wdata_i[CB_CLE]) &&
      nand_ale_o == $past(wdata_i[CB_ALE]) && nand_nwp_o == !$past(wdata_i[CB_WP])));
  // R10
  clr_keeps_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_clr |=> $stable(ctl_q));
  // R12
  reg_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_io) |=> ack_o);
  // R12
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !xfer_done) |-> !reg_ack_q);
endmodule

// File: tb/test_nfc_host_top.sv
module test_nfc_host_top;
  localparam int P = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, word = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        cle, ale, nce, nwp, nwe, nre, rb = 1'b0, oe;
  logic [7:0]  dq_in, dq_out;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  nfc_host_top #(.PULSE_CYC(P)) i_nfc_host_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_nce_o(nce), .nand_nwp_o(nwp),
    .nand_nwe_o(nwe), .nand_nre_o(nre), .nand_rb_i(rb),
    .nand_dq_i(dq_in), .nand_dq_o(dq_out), .nand_dq_oe_o(oe));

  // device model
  logic [7:0] rd_mem [8] = '{8'h3C, 8'hE1, 8'h07, 8'h99, 8'h00, 8'hFF, 8'h5A, 8'h81};
  int rd_ptr = 0;
  int nre_pulses = 0;
  logic [7:0] wr_log = '0;
  logic       wr_oe = 1'b0;
  assign dq_in = rd_mem[rd_ptr % 8];
  always @(posedge nre) if (rst_n) begin rd_ptr++; nre_pulses++; end
  always @(posedge nwe) if (rst_n) begin wr_log = dq_out; wr_oe = oe; end

  // ECC reference
  logic [7:0] m_e = '0, m_o = '0;
  logic [5:0] m_cp = '0;
  int         m_cnt = 0;

  task automatic m_dig(input logic [7:0] b);
    logic p;
    p = ^b;
    for (int k = 0; k < 8; k++)
      if (((m_cnt >> k) & 1) != 0) m_o[k] ^= p; else m_e[k] ^= p;
    for (int j = 0; j < 3; j++)
      for (int n = 0; n < 8; n++)
        if (((n >> j) & 1) != 0) m_cp[2*j+1] ^= b[n]; else m_cp[2*j] ^= b[n];
    m_cnt++;
  endtask

  task automatic m_clear();
    m_e = '0; m_o = '0; m_cp = '0; m_cnt = 0;
  endtask

  function automatic logic [7:0] exp_lp(input logic hi_reg);
    logic [7:0] r;
    for (int j = 0; j < 4; j++) begin
      r[2*j]   = hi_reg ? m_e[j] : m_e[4+j];
      r[2*j+1] = hi_reg ? m_o[j] : m_o[4+j];
    end
    return r;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  int lat;
  task automatic access(input logic w, input logic wd, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; word = wd; addr = a; wdata = d;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req = 1'b0;
    while (!ack && lat < 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
  endtask

  task automatic chk_ecc(input string tag);
    access(1'b0, 1'b0, 6'h0C, 8'h00); chk("R7", {tag, " count"}, rdata, 32'(m_cnt % 256));
    access(1'b0, 1'b0, 6'h08, 8'h00); chk("R8", {tag, " colpar"}, rdata, {26'h0, m_cp});
    access(1'b0, 1'b0, 6'h00, 8'h00); chk("R9", {tag, " lp low"}, rdata, {24'h0, exp_lp(1'b0)});
    access(1'b0, 1'b0, 6'h04, 8'h00); chk("R9", {tag, " lp high"}, rdata, {24'h0, exp_lp(1'b1)});
  endtask

  // {wdata, cle, ale, nce, nwp}
  localparam logic [11:0] CTL_TAB [7] = '{
    {8'h01, 4'b0001}, {8'h02, 4'b1011}, {8'h04, 4'b0111}, {8'h08, 4'b0010},
    {8'h10, 4'b0001}, {8'h3F, 4'b1100}, {8'h13, 4'b1001}};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pins", {cle, ale, nce, nwp}, 4'b0011);
    access(1'b0, 1'b0, 6'h18, 8'h00); chk("R1", "ctl", rdata, 32'h0);
    chk_ecc("R1 reset");

    // R2/R3 control table
    for (int i = 0; i < 7; i++) begin
      access(1'b1, 1'b0, 6'h18, CTL_TAB[i][11:4]);
      chk("R2", "pins", {cle, ale, nce, nwp}, CTL_TAB[i][3:0]);
      access(1'b0, 1'b0, 6'h18, 8'h00);
      chk("R3", "ctl readback", rdata, {24'h0, CTL_TAB[i][11:4] & 8'hDF});
    end
    rb = 1'b1;
    access(1'b0, 1'b0, 6'h18, 8'h00); chk("R3", "ready bit", rdata, 32'h33);
    rb = 1'b0;
    chk("R12", "reg latency", lat, 1);

    // R4 byte write
    access(1'b1, 1'b0, 6'h14, 8'hA5); m_dig(8'hA5);
    chk("R4", "written byte", {wr_oe, wr_log}, {1'b1, 8'hA5});
    chk("R12", "io byte latency", lat, P + 2);
    access(1'b1, 1'b0, 6'h14, 8'h6E); m_dig(8'h6E);
    chk("R4", "written byte 2", wr_log, 8'h6E);

    // R5 byte read
    access(1'b0, 1'b0, 6'h14, 8'h00); m_dig(8'h3C);
    chk("R5", "read byte", rdata, 32'h0000_003C);
    chk("R12", "io read latency", lat, P + 2);

    // R6 word read
    access(1'b0, 1'b1, 6'h14, 8'h00); m_dig(8'hE1); m_dig(8'h07);
    chk("R6", "word read", rdata, 32'h0007_00E1);
    chk("R6", "strobes", nre_pulses, 3);
    chk("R12", "io word latency", lat, 2 * P + 3);
    chk_ecc("mixed");

    // R10 clear with arbitrary data
    access(1'b1, 1'b0, 6'h10, 8'h5A); m_clear();
    chk_ecc("R10 after clear");
    chk("R10", "pins kept", {cle, ale, nce, nwp}, 4'b1001);

    // R11 undefined offsets
    access(1'b0, 1'b0, 6'h01, 8'h00); chk("R11", "read 0x01", rdata, 32'h0);
    access(1'b0, 1'b0, 6'h3C, 8'h00); chk("R11", "read 0x3C", rdata, 32'h0);
    access(1'b0, 1'b0, 6'h10, 8'h00); chk("R11", "read clear reg", rdata, 32'h0);
    access(1'b1, 1'b0, 6'h1C, 8'hFF);
    chk("R11", "pins after bad write", {cle, ale, nce, nwp}, 4'b1001);
    access(1'b0, 1'b0, 6'h18, 8'h00); chk("R11", "ctl after bad write", rdata, 32'h13);

    // full 256-byte block, then wrap
    for (int i = 0; i < 256; i++) begin
      access(1'b1, 1'b0, 6'h14, 8'((i * 37 + 5) % 256)); m_dig(8'((i * 37 + 5) % 256));
    end
    chk_ecc("block 256");
    for (int i = 0; i < 3; i++) begin
      access(1'b0, 1'b1, 6'h14, 8'h00);
      m_dig(rd_mem[(rd_ptr - 2) % 8]); m_dig(rd_mem[(rd_ptr - 1) % 8]);
    end
    chk_ecc("wrap");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule